// File: doc/BRIEF.md
# Sixteen-Channel Split-Nibble PWM Generator

This block drives sixteen pulse-width-modulated outputs that share one timebase. Each conversion period is 256 ticks long and is cut into sixteen basic pulses of sixteen ticks each. The upper half of a channel's 8-bit setting fixes the high width of every basic pulse. The lower half picks how many of the sixteen basic pulses are stretched by a single tick. The average level therefore resolves in 1/256 steps, while the output ripple sits at sixteen times the period rate. A shared prescaler sets the tick to the system clock divided by 1, 2, 4, 8 or 16.

Settings and per-channel polarity are loaded through a synchronous write port with an address. A new setting is held in a staging register. It reaches the output only at a period boundary, or when the counters restart after a prescaler change, so no period ever mixes two settings. A polarity bit inverts its channel, and the setting then gives the low width.

Top module: `pwm_ap_top`

## Requirements
- R1: `presc_sel` values 0, 1, 2, 3 and 4 give one tick every 1, 2, 4, 8 and 16 clocks. Values 5 to 7 behave as 4 (every 16 clocks). A conversion period is 256 ticks, so one period lasts 256 × divisor clocks.
- R2: A basic pulse is 16 ticks and a period is 16 basic pulses. A change on `presc_sel` is sampled at a clock edge and restarts the counters at tick 0 of a period. The output for tick 0 is visible after the following clock edge, and each tick then lasts one divisor's worth of clocks.
- R3: Within basic pulse k, the output is high at tick positions p = 0 upward while p < hi + e(k), and low for the rest of the pulse. Here hi = setting bits 7:4, and e(k) is 1 for an extended pulse and 0 otherwise. A setting of 0x00 keeps the output low.
- R4: Basic pulse k (0 to 15) is extended when the 4-bit bit-reversal of k is less than setting bits 3:0. The high ticks per period are 16·hi + bits 3:0. A setting of 0xFF gives 255 of 256, so a full-on period never occurs.
- R5: Write addresses 0 to 15 select the settings of channels 0 to 15. Address 16 holds the polarity of channels 0 to 7, with bit n mapping to channel n. Address 17 holds the polarity of channels 8 to 15, with bit n mapping to channel 8+n. Writes to addresses 18 to 31 have no effect on any output.
- R6: A written setting or polarity takes effect only at the next period boundary or counter restart. The period in progress keeps its old values.
- R7: A polarity bit of 1 inverts its channel, so the high ticks per period become 256 − (16·hi + lo).
- R8: After reset, all settings and polarities are 0 and every output is low.
- R9: Each channel follows only its own setting and polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_sel | input | 3 | Tick divisor select (R1) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address (R5) |
| wr_data | input | 8 | Write data |
| pwm_out | output | 16 | Channel outputs, bit n is channel n |

## Verification
The bench checks the shape of each basic pulse tick by tick against the bit-reversal rule. A design that extended the first lo pulses, or that put the extra tick somewhere other than straight after the base width, would fail. A setting rewritten in the middle of a period must leave that period intact, so a design without staging shows a count between the old and new values. The all-ones setting must stop one tick short of full. The bench also runs an out-of-range prescaler code, the high polarity byte and the unused addresses, where a design with a wrong decode would inflate the counts, invert the wrong channel or corrupt a setting.

// File: rtl/pwm_ap_pkg.sv
package pwm_ap_pkg;
    localparam int NIB_W  = 4;
    localparam int DATA_W = 2 * NIB_W;
    localparam int SEL_W  = 3;

    function automatic logic [NIB_W-1:0] nib_reverse(input logic [NIB_W-1:0] v);
        logic [NIB_W-1:0] r;
        for (int b = 0; b < NIB_W; b++) r[b] = v[NIB_W-1-b];
        return r;
    endfunction
endpackage

// File: rtl/pwm_ap_prescale.sv
module pwm_ap_prescale
    import pwm_ap_pkg::*;
#(
    parameter int CNT_W = NIB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick,
    output logic             restart
);
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] cnt;
    } ps_t;

    ps_t st_d, st_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        st_d    = st_q;
        restart = (sel != st_q.sel);
        if (st_q.sel >= SEL_W'(CNT_W)) lim = '1;
        else                           lim = CNT_W'((1 << st_q.sel) - 1);
        tick    = !restart && (st_q.cnt == lim);
        st_d.sel = sel;
        if (restart || tick) st_d.cnt = '0;
        else                 st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: with a divisor above one, ticks never come back to back
    p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.sel != '0) |=> !tick);
endmodule

// File: rtl/pwm_ap_timebase.sv
module pwm_ap_timebase
    import pwm_ap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    output logic [NIB_W-1:0] pos,
    output logic [NIB_W-1:0] idx,
    output logic             load
);
    typedef struct packed {
        logic [NIB_W-1:0] pos;
        logic [NIB_W-1:0] idx;
    } tb_t;

    tb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        load = restart || (tick && st_q.pos == '1 && st_q.idx == '1);
        if (restart) begin
            st_d.pos = '0;
            st_d.idx = '0;
        end else if (tick) begin
            st_d.pos = st_q.pos + 1'b1;
            if (st_q.pos == '1) st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos = st_q.pos;
    assign idx = st_q.idx;

    // R2: a prescaler change lands the counters on tick 0 of a period
    p_restart_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pos == '0 && idx == '0));
    // R2: the pulse index advances once per completed basic pulse
    p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && pos == '1) |=> (idx == $past(idx) + 1'b1 && pos == '0));
endmodule

// File: rtl/pwm_ap_regs.sv
module pwm_ap_regs
    import pwm_ap_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          load,
    output logic [NUM_CH-1:0][DATA_W-1:0] cur_data,
    output logic [NUM_CH-1:0]             cur_pol
);
    localparam int POL_BYTES = NUM_CH / DATA_W;

    typedef struct packed {
        logic [NUM_CH-1:0][DATA_W-1:0] stg_data;
        logic [NUM_CH-1:0]             stg_pol;
        logic [NUM_CH-1:0][DATA_W-1:0] run_data;
        logic [NUM_CH-1:0]             run_pol;
    } rf_t;

    rf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int c = 0; c < NUM_CH; c++)
                if (wr_addr == ADDR_W'(c)) st_d.stg_data[c] = wr_data;
            for (int j = 0; j < POL_BYTES; j++)
                if (wr_addr == ADDR_W'(NUM_CH + j))
                    st_d.stg_pol[j*DATA_W +: DATA_W] = wr_data;
        end
        if (load) begin
            st_d.run_data = st_q.stg_data;
            st_d.run_pol  = st_q.stg_pol;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_data = st_q.run_data;
    assign cur_pol  = st_q.run_pol;

    // R6: running values only move at a period boundary or restart
    p_hold_midperiod_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(cur_data) && $stable(cur_pol)));
endmodule

// File: rtl/pwm_ap_channel.sv
module pwm_ap_channel
    import pwm_ap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data,
    input  logic              pol,
    input  logic [NIB_W-1:0]  pos,
    input  logic [NIB_W-1:0]  idx,
    output logic              out
);
    typedef struct packed {
        logic out;
    } ch_t;

    ch_t st_d, st_q;
    logic [NIB_W-1:0] hi, lo;
    logic             ext, high;

    always_comb begin
        st_d = st_q;
        hi   = data[DATA_W-1:NIB_W];
        lo   = data[NIB_W-1:0];
        ext  = nib_reverse(idx) < lo;
        high = {1'b0, pos} < ({1'b0, hi} + (NIB_W+1)'(ext));
        st_d.out = high ^ pol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out = st_q.out;

    // R3: a zero setting keeps a direct channel low
    p_zero_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data == '0 && !pol) |=> !out);
    // R4: the last tick of a period is never high on a direct channel
    p_no_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pol && pos == '1 && idx == '1) |=> !out);
    // R7: an inverted channel with a zero setting stays high
    p_invert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data == '0 && pol) |=> out);
endmodule

// File: rtl/pwm_ap_top.sv
module pwm_ap_top
    import pwm_ap_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = $clog2(NUM_CH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  presc_sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NUM_CH-1:0] pwm_out
);
    logic                          tick, restart, load;
    logic [NIB_W-1:0]              pos, idx;
    logic [NUM_CH-1:0][DATA_W-1:0] cur_data;
    logic [NUM_CH-1:0]             cur_pol;

    pwm_ap_prescale #(.CNT_W(NIB_W)) u_prescale (
        .clk(clk), .rst_n(rst_n), .sel(presc_sel),
        .tick(tick), .restart(restart)
    );

    pwm_ap_timebase u_timebase (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
        .pos(pos), .idx(idx), .load(load)
    );

    pwm_ap_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .load(load),
        .cur_data(cur_data), .cur_pol(cur_pol)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_ap_channel u_ch (
            .clk(clk), .rst_n(rst_n), .data(cur_data[g]), .pol(cur_pol[g]),
            .pos(pos), .idx(idx), .out(pwm_out[g])
        );
    end
endmodule

// File: tb/test_pwm_ap_top.sv
module test_pwm_ap_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  presc_sel = 3'd0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] pwm_out;

    int checks = 0;
    int fails  = 0;
    logic [7:0]  m_data [16];
    logic [15:0] m_pol = '0;
    logic [15:0] samp [512];
    int          cnt  [16];

    always #10 clk = ~clk;

    pwm_ap_top i_pwm_ap_top (
        .clk(clk), .rst_n(rst_n), .presc_sel(presc_sel), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
    );

    function automatic int rev4(input int k);
        return ((k & 1) << 3) | ((k & 2) << 1) | ((k & 4) >> 1) | ((k & 8) >> 3);
    endfunction

    function automatic int exp_high(input int ch);
        int h;
        h = 16 * int'(m_data[ch][7:4]) + int'(m_data[ch][3:0]);
        return m_pol[ch] ? 256 - h : h;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d);
        if (a < 16) m_data[a] = 8'(d);
        else if (a == 16) m_pol[7:0] = 8'(d);
        else if (a == 17) m_pol[15:8] = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // ends at the negedge where tick 0 of a fresh period is shown
    task automatic restart_to(input int s);
        @(negedge clk);
        if (presc_sel == 3'(s)) begin
            presc_sel = 3'(s) ^ 3'd1;
            @(negedge clk);
        end
        presc_sel = 3'(s);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic capture(input int n, input int wr_at, input int wa, input int wd);
        for (int c = 0; c < 16; c++) cnt[c] = 0;
        for (int i = 0; i < n; i++) begin
            if (i < 512) samp[i] = pwm_out;
            for (int c = 0; c < 16; c++) cnt[c] += int'(pwm_out[c]);
            if (i == wr_at) begin
                wr_en = 1'b1; wr_addr = 5'(wa); wr_data = 8'(wd);
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic check_all(input string req, input int div);
        for (int c = 0; c < 16; c++) chk(req, cnt[c], exp_high(c) * div);
    endtask

    task automatic t_reset;
        int ones = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (pwm_out != '0) ones++;
        end
        chk("R8 outputs low after reset", ones, 0);
    endtask

    task automatic t_duty_div1;
        wr(0, 8'h00); wr(1, 8'hFF); wr(2, 8'h5A); wr(3, 8'h10); wr(4, 8'h01);
        restart_to(0);
        capture(256, -1, 0, 0);
        chk("R3 zero setting", cnt[0], 0);
        chk("R4 all ones gives 255", cnt[1], 255);
        chk("R1 div1 period count 0x5A", cnt[2], 90);
        chk("R3 coarse only", cnt[3], 16);
        chk("R4 single extension", cnt[4], 1);
    endtask

    task automatic t_shape;
        int bad;
        int ch_list [3] = '{5, 6, 7};
        wr(5, 8'h31); wr(6, 8'h08); wr(7, 8'hF7);
        restart_to(0);
        capture(256, -1, 0, 0);
        foreach (ch_list[n]) begin
            int c = ch_list[n];
            int hi = int'(m_data[c][7:4]);
            int lo = int'(m_data[c][3:0]);
            bad = 0;
            for (int k = 0; k < 16; k++)
                for (int p = 0; p < 16; p++) begin
                    int w = hi + ((rev4(k) < lo) ? 1 : 0);
                    if (samp[k*16+p][c] != (p < w)) bad++;
                end
            chk("R3/R4 tick-exact pulse shape (R2 alignment)", bad, 0);
        end
    endtask

    task automatic t_prescale;
        restart_to(2);
        capture(1024, -1, 0, 0);
        check_all("R1 divide by 4", 4);
        restart_to(7);
        capture(4096, -1, 0, 0);
        check_all("R1 code 7 divides by 16", 16);
    endtask

    task automatic t_shadow;
        int a = 0, b = 0;
        wr(8, 8'h80);
        restart_to(0);
        capture(512, 100, 8, 8'h20);
        m_data[8] = 8'h20;
        for (int i = 0; i < 256; i++) a += int'(samp[i][8]);
        for (int i = 256; i < 512; i++) b += int'(samp[i][8]);
        chk("R6 period in progress keeps old value", a, 128);
        chk("R6 next period uses new value", b, 32);
    endtask

    task automatic t_polarity;
        wr(3, 8'h00); wr(9, 8'h40);
        wr(16, 8'h08); wr(17, 8'h02);
        restart_to(0);
        capture(256, -1, 0, 0);
        chk("R7 inverted zero setting", cnt[3], 256);
        chk("R7/R5 high polarity byte ch9", cnt[9], 192);
        check_all("R9/R5 polarity per channel", 1);
        wr(16, 0); wr(17, 0);
    endtask

    task automatic t_channels;
        for (int c = 0; c < 16; c++) wr(c, (c * 37 + 5) & 255);
        restart_to(0);
        capture(256, -1, 0, 0);
        check_all("R9 independent channels", 1);
    endtask

    task automatic t_ignored;
        wr(18, 8'hFF); wr(24, 8'hA5); wr(31, 8'hFF);
        restart_to(0);
        capture(256, -1, 0, 0);
        check_all("R5 unused addresses ignored", 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 16; c++) m_data[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_duty_div1();
        t_shape();
        t_prescale();
        t_shadow();
        t_polarity();
        t_channels();
        t_ignored();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule